// File: doc/BRIEF.md
# End-Around-Carry Modular Adder

This block adds two n-bit operands in one of two modular systems. The carry out of the top bit position is routed back in as the carry into the low end. In one's complement mode that carry is used unchanged, so the sum is reduced modulo 2^n-1. In diminished-one mode the carry is inverted before it is fed back, which gives addition modulo 2^n+1 on operands stored as value minus one.

The datapath has three parts. Bitwise generate and propagate terms feed a parallel-prefix tree. That tree computes group terms from bit 0 up to every bit with no carry-in. A single row of selection logic then uses the fed-back carry to choose, for each bit, between the zero-carry and one-carry prefix results. The sum bits are formed from those carries and registered once, together with a valid flag. The block expects operands already in the chosen representation. It does not normalise a result.

Top module: `eac_modadd`

## Requirements
- R1: With `mode_dim1` = 0 (one's complement), the registered sum equals a+b when a+b < 2^n, and a+b-2^n+1 otherwise. The result is therefore congruent to a+b modulo 2^n-1.
- R2: In one's complement mode, operands with b equal to the bitwise inverse of a produce the all-ones word. The block does not turn that result into all zeros.
- R3: With `mode_dim1` = 1 (diminished-one), the registered sum equals a+b-2^n when a+b >= 2^n, and (a+b+1) mod 2^n otherwise. Whenever ((a+1)+(b+1)) mod (2^n+1) is nonzero, this equals that residue minus one.
- R4: In diminished-one mode, an operand a of zero yields (b+1) mod 2^n. In one's complement mode, an operand a of zero yields b.
- R5: The sum for the operands present at a rising edge where `in_vld` = 1 appears on `sum_q` after that edge. `out_vld` equals `in_vld` as it was at the previous edge.
- R6: At an edge where `in_vld` = 0, `sum_q` keeps its previous value whatever the operands and mode are.
- R7: A synchronous active-high `rst` clears `sum_q` to zero and `out_vld` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid; loads the output register |
| mode_dim1 | input | 1 | 0: one's complement (mod 2^n-1), 1: diminished-one (mod 2^n+1) |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum_q | output | WIDTH | Registered modular sum |
| out_vld | output | 1 | Registered valid, one cycle after `in_vld` |

## Verification
The bench builds the adder with WIDTH = 6. At that width every operand pair in both modes can be driven: 4096 pairs per mode. This covers every carry-out case, including the full-propagate chain where the fed-back carry decides every bit and the overflow patterns that wrap. A six-bit word also gives the prefix tree three levels with non-power-of-two spans at the top, so the index arithmetic of the tree is exercised beyond a trivial size. Expected sums come from integer arithmetic on the operands. Each result is also checked against the true residue modulo 63 or 65.

// File: rtl/eac_pkg.sv
package eac_pkg;

  typedef enum logic {
    EAC_ONES = 1'b0,
    EAC_DIM1 = 1'b1
  } eac_mode_e;

  // number of prefix levels needed to span w bits
  function automatic int eac_levels(input int w);
    int n;
    n = 0;
    while ((1 << n) < w) n++;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/eac_pregen.sv
module eac_pregen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_bit
      assign gen_o[k]  = a_in[k] & b_in[k];
      assign prop_o[k] = a_in[k] ^ b_in[k];
    end
  endgenerate

  // a bit cannot both generate and propagate
  always_comb begin
    gp_excl_chk : assert ((gen_o & prop_o) == '0)
      else $error("generate and propagate overlap");
  end

endmodule

// File: rtl/eac_prefix_tree.sv
module eac_prefix_tree
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic [WIDTH-1:0] grp_gen_o,
  output logic [WIDTH-1:0] grp_prop_o
);

  localparam int LVLS = eac_levels(WIDTH);

  logic [WIDTH-1:0] gl [0:LVLS];
  logic [WIDTH-1:0] pl [0:LVLS];

  assign gl[0] = gen_i;
  assign pl[0] = prop_i;

  genvar l, i;
  generate
    for (l = 0; l < LVLS; l++) begin : g_lvl
      for (i = 0; i < WIDTH; i++) begin : g_node
        if (((i >> l) & 1) == 1) begin : g_merge
          // partner is the top bit of the lower half of this span
          localparam int J = ((i >> l) << l) - 1;
          assign gl[l+1][i] = gl[l][i] | (pl[l][i] & gl[l][J]);
          assign pl[l+1][i] = pl[l][i] & pl[l][J];
        end else begin : g_pass
          assign gl[l+1][i] = gl[l][i];
          assign pl[l+1][i] = pl[l][i];
        end
      end
    end
  endgenerate

  assign grp_gen_o  = gl[LVLS];
  assign grp_prop_o = pl[LVLS];

  // a group cannot generate while all of its bits propagate
  always_comb begin
    grp_excl_chk : assert ((grp_gen_o & grp_prop_o) == '0)
      else $error("group generate with full propagate");
  end

endmodule

// File: rtl/eac_fold_row.sv
module eac_fold_row #(
  parameter int WIDTH = 16
) (
  input  logic             dim1_i,
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] grp_gen_i,
  input  logic [WIDTH-1:0] grp_prop_i,
  output logic [WIDTH-1:0] sum_o
);

  logic             carry_top;
  logic             eac_cin;   // high-fanout fed-back carry, one net
  logic [WIDTH-1:0] bit_cin;

  assign carry_top = grp_gen_i[WIDTH-1];
  assign eac_cin   = dim1_i ? ~carry_top : carry_top;

  assign bit_cin[0] = eac_cin;
  genvar k;
  generate
    for (k = 1; k < WIDTH; k++) begin : g_sel
      assign bit_cin[k] = eac_cin ? (grp_gen_i[k-1] | grp_prop_i[k-1])
                                  : grp_gen_i[k-1];
    end
  endgenerate

  assign sum_o = prop_i ^ bit_cin;

  // R2: one's complement full propagate gives all ones
  always_comb begin
    if (!dim1_i && (prop_i == '1)) begin
      ones_zero_chk : assert (sum_o == '1)
        else $error("all-ones result altered");
    end
  end

endmodule

// File: rtl/eac_modadd.sv
module eac_modadd
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             mode_dim1,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum_q,
  output logic             out_vld
);

  logic [WIDTH-1:0] gen_w, prop_w, ggen_w, gprop_w, sum_w;
  eac_mode_e        mode_w;

  assign mode_w = eac_mode_e'(mode_dim1);

  eac_pregen #(.WIDTH(WIDTH)) u_pre (
    .a_in   (op_a),
    .b_in   (op_b),
    .gen_o  (gen_w),
    .prop_o (prop_w)
  );

  eac_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .gen_i      (gen_w),
    .prop_i     (prop_w),
    .grp_gen_o  (ggen_w),
    .grp_prop_o (gprop_w)
  );

  eac_fold_row #(.WIDTH(WIDTH)) u_fold (
    .dim1_i     (mode_w == EAC_DIM1),
    .prop_i     (prop_w),
    .grp_gen_i  (ggen_w),
    .grp_prop_i (gprop_w),
    .sum_o      (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) sum_q <= sum_w;
    end
  end

  // R5
  vld_delay_chk : assert property (@(posedge clk) disable iff (rst)
    out_vld == $past(in_vld))
    else $error("valid not delayed by one");

  // R6
  sum_hold_chk : assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(sum_q))
    else $error("sum changed without valid");

  // R2
  ones_inv_chk : assert property (@(posedge clk) disable iff (rst)
    (in_vld && !mode_dim1 && (op_a == ~op_b)) |=> (sum_q == '1))
    else $error("complementary operands did not give all ones");

  // R4
  dim_zero_chk : assert property (@(posedge clk) disable iff (rst)
    (in_vld && mode_dim1 && (op_a == '0)) |=> (sum_q == $past(op_b) + 1'b1))
    else $error("diminished-one zero operand wrong");

  // R4
  ones_ident_chk : assert property (@(posedge clk) disable iff (rst)
    (in_vld && !mode_dim1 && (op_a == '0)) |=> (sum_q == $past(op_b)))
    else $error("one's complement identity wrong");

endmodule

// File: tb/eac_modadd_tb.sv
`timescale 1ns/1ps
module eac_modadd_tb_top;

  localparam int W   = 6;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_vld;
  logic         mode_dim1;
  logic [W-1:0] op_a, op_b;
  logic [W-1:0] sum_q;
  logic         out_vld;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  eac_modadd #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .mode_dim1(mode_dim1),
    .op_a(op_a), .op_b(op_b), .sum_q(sum_q), .out_vld(out_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input bit v, input bit m, input int a, input int b);
    @(negedge clk);
    in_vld = v; mode_dim1 = m; op_a = W'(a); op_b = W'(b);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_vld = 1'b0; mode_dim1 = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 sum", int'(sum_q), 0);
    check("R7 vld", int'(out_vld), 0);
    @(negedge clk); rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < MOD; a++) begin
        for (int b = 0; b < MOD; b++) begin
          int t, e;
          t = a + b;
          apply(1'b1, m[0], a, b);
          check("R5 vld", int'(out_vld), 1);
          if (m == 0) begin
            e = (t >= MOD) ? t - MOD + 1 : t;
            check("R1 sum", int'(sum_q), e);
            check("R1 residue", int'(sum_q) % (MOD - 1), t % (MOD - 1));
            if (b == ((~a) & (MOD - 1))) check("R2 ones", int'(sum_q), MOD - 1);
            if (a == 0) check("R4 ones zero", int'(sum_q), b);
          end else begin
            int r;
            e = (t >= MOD) ? t - MOD : (t + 1) % MOD;
            check("R3 sum", int'(sum_q), e);
            r = (a + 1 + b + 1) % (MOD + 1);
            if (r != 0) check("R3 residue", int'(sum_q), r - 1);
            if (a == 0) check("R4 dim zero", int'(sum_q), (b + 1) % MOD);
          end
        end
      end
    end

    // R6: hold while in_vld is low
    apply(1'b1, 1'b0, 5, 9);
    check("R5 load", int'(sum_q), 14);
    apply(1'b0, 1'b1, 63, 63);
    check("R6 hold", int'(sum_q), 14);
    check("R5 vld low", int'(out_vld), 0);
    apply(1'b0, 1'b0, 33, 40);
    check("R6 hold", int'(sum_q), 14);
    apply(1'b1, 1'b1, 63, 63);
    check("R5 reload", int'(sum_q), 62);
    check("R5 vld high", int'(out_vld), 1);

    // R7: reset after activity
    @(negedge clk); rst = 1'b1; in_vld = 1'b1;
    @(posedge clk); #1;
    check("R7 sum clr", int'(sum_q), 0);
    check("R7 vld clr", int'(out_vld), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule